// File: doc/BRIEF.md
# Phase-Accumulator Fractional Clock Divider

This block derives a slower clock from a fast input clock without limiting the ratio to whole numbers. On every rising edge of the input clock, an accumulator of N+1 bits adds a step value, and the accumulator's top bit is the divided clock. Because the accumulator wraps modulo 2^(N+1), the output frequency is f_in × K / 2^(N+1) for a step K between 1 and 2^N. The output therefore runs anywhere from half the input rate down to 1/2^(N+1) of it. Ratios such as 15 output periods per 32 input cycles come out directly.

The step is taken from the increment input and conditioned first. A zero request becomes one, and anything above 2^N is limited to 2^N. The conditioned step is captured while reset is held. After that it is reloaded only on the edge where the accumulator wraps, so a change to the increment takes effect once per output period and never in the middle of one. A second output carries a one-cycle pulse that lines up with each rising edge of the divided clock, for logic that wants an enable rather than a derived clock.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high on a rising edge of `clk`, the accumulator clears to zero, so `clk_o` and `edge_o` are both low in the following cycle. The conditioned increment is loaded as the step in that same edge.
- R2: On each rising edge out of reset, the accumulator advances by the current step modulo 2^(N+1), and `clk_o` equals bit N (the MSB) of the accumulator.
- R3: An increment of 0 acts as a step of 1, giving the lowest rate: one output period every 2^(N+1) input cycles.
- R4: Any increment above 2^N acts as a step of 2^N, giving the highest rate: `clk_o` toggles on every input cycle.
- R5: With a constant step K held from reset, exactly K rising edges of `clk_o` occur in the first 2^(N+1) cycles after reset. An example of such a fractional ratio is K = 15 with N = 4.
- R6: `edge_o` is high for exactly those cycles in which `clk_o` is 1 and was 0 in the previous cycle.
- R7: Out of reset, the step changes only on an edge at which the accumulator carries out of bit N. That edge takes the conditioned increment present at it. An increment change at any other edge has no effect until the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| incr_i | input | N+1 | Requested step per input cycle, 0 to 2^(N+1)-1 before conditioning |
| clk_o | output | 1 | Divided clock, the accumulator MSB |
| edge_o | output | 1 | One-cycle pulse concurrent with each rising edge of `clk_o` |

## Verification
The step reload and the increment change are the two functions that can fall in the same cycle. The question is whether a new increment presented exactly on a wrap edge is taken at once, while one presented a cycle earlier or later waits a full output period. The bench provokes this by changing the increment on every cycle from a pseudo-random sequence, so that changes land on wrap edges as well as between them. A cycle-by-cycle arithmetic model, which reloads its step only when its own sum carries, judges `clk_o` and `edge_o` on every cycle. A full sweep over all 32 increment codes also covers the clamping corners and the per-revolution edge counts.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;

    // Default number of step bits; the accumulator is one bit wider.
    localparam int unsigned DEF_STEP_BITS = 4;

    // Conditioned step: 0 becomes 1, values above the limit saturate.
    function automatic int unsigned cond_step(input int unsigned raw,
                                              input int unsigned lim);
        if (raw == 0)
            return 1;
        else if (raw > lim)
            return lim;
        else
            return raw;
    endfunction

    // Result of one accumulator addition.
    typedef struct packed {
        logic carry;
        logic msb;
    } add_flags_t;

endpackage

// File: rtl/frac_step_cond.sv
module frac_step_cond #(
    parameter int unsigned N = frac_clk_div_pkg::DEF_STEP_BITS
) (
    input  logic [N:0] raw_i,
    output logic [N:0] step_o
);
    localparam int unsigned ACC_W = N + 1;
    localparam logic [ACC_W-1:0] STEP_MAX = ACC_W'(1) << N;
    localparam logic [ACC_W-1:0] STEP_MIN = ACC_W'(1);

    always_comb begin
        if (raw_i == '0)
            step_o = STEP_MIN;
        else if (raw_i > STEP_MAX)
            step_o = STEP_MAX;
        else
            step_o = raw_i;
    end
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned N = DEF_STEP_BITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [N:0] step_in_i,
    output logic [N:0] acc_o,
    output logic [N:0] step_o,
    output add_flags_t flags_o
);
    localparam int unsigned ACC_W = N + 1;

    logic [ACC_W-1:0] acc_r;
    logic [ACC_W-1:0] step_r;
    logic [ACC_W:0]   sum_w;

    always_comb begin
        sum_w         = {1'b0, acc_r} + {1'b0, step_r};
        flags_o.carry = sum_w[ACC_W];
        flags_o.msb   = sum_w[ACC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r  <= '0;
            step_r <= step_in_i;
        end else begin
            acc_r <= sum_w[ACC_W-1:0];
            if (flags_o.carry)
                step_r <= step_in_i;
        end
    end

    assign acc_o  = acc_r;
    assign step_o = step_r;
endmodule

// File: rtl/frac_edge_pulse.sv
module frac_edge_pulse (
    input  logic clk,
    input  logic rst,
    input  logic msb_now_i,
    input  logic msb_next_i,
    output logic pulse_o
);
    logic pulse_r;

    always_ff @(posedge clk) begin
        if (rst)
            pulse_r <= 1'b0;
        else
            pulse_r <= msb_next_i & ~msb_now_i;
    end

    assign pulse_o = pulse_r;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned N = DEF_STEP_BITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [N:0] incr_i,
    output logic       clk_o,
    output logic       edge_o
);
    logic [N:0] step_c;
    logic [N:0] acc_q;
    logic [N:0] step_q;
    add_flags_t flags;

    frac_step_cond #(.N(N)) cond_i (
        .raw_i  (incr_i),
        .step_o (step_c)
    );

    frac_phase_acc #(.N(N)) acc_i (
        .clk       (clk),
        .rst       (rst),
        .step_in_i (step_c),
        .acc_o     (acc_q),
        .step_o    (step_q),
        .flags_o   (flags)
    );

    frac_edge_pulse pulse_i (
        .clk        (clk),
        .rst        (rst),
        .msb_now_i  (acc_q[N]),
        .msb_next_i (flags.msb),
        .pulse_o    (edge_o)
    );

    assign clk_o = acc_q[N];
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
    parameter int unsigned N = frac_clk_div_pkg::DEF_STEP_BITS
) (
    input logic       clk,
    input logic       rst,
    input logic       clk_o,
    input logic       edge_o,
    input logic [N:0] acc_q,
    input logic [N:0] step_q
);
    localparam int unsigned ACC_W = N + 1;
    localparam logic [ACC_W-1:0] STEP_MAX = ACC_W'(1) << N;

    logic [ACC_W:0] sum_w;
    assign sum_w = {1'b0, acc_q} + {1'b0, step_q};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !clk_o && !edge_o));

    // R2
    acc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc_q == ACC_W'($past(acc_q) + $past(step_q)));

    // R3
    step_floor_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> step_q != '0);

    // R4
    step_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> step_q <= STEP_MAX);

    // R6
    edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> edge_o == (clk_o && !$past(clk_o)));

    // R7
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sum_w[ACC_W])) |-> $stable(step_q));
endmodule

bind frac_clk_div frac_clk_div_chk #(.N(N)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .clk_o  (clk_o),
    .edge_o (edge_o),
    .acc_q  (acc_q),
    .step_q (step_q)
);

// File: tb/frac_clk_div_tb_top.sv
`timescale 1ns/1ps
module frac_clk_div_tb_top;
    localparam int unsigned N = 4;
    localparam int unsigned MODV = 1 << (N + 1);
    localparam int unsigned LIM = 1 << N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N:0] incr = '0;
    logic clk_o, edge_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int unsigned m_acc;
    int unsigned m_step;

    always #5 clk = ~clk;

    frac_clk_div #(.N(N)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .incr_i (incr),
        .clk_o  (clk_o),
        .edge_o (edge_o)
    );

    function automatic int unsigned cnd(input int unsigned r);
        if (r == 0) return 1;
        if (r > LIM) return LIM;
        return r;
    endfunction

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset for a few cycles with the given increment, then release.
    task automatic do_reset(input int unsigned k);
        @(negedge clk);
        rst  = 1'b1;
        incr = (N+1)'(k);
        repeat (3) @(negedge clk);
        chk("R1 clk_o in reset", clk_o, 0);
        chk("R1 edge_o in reset", edge_o, 0);
        rst    = 1'b0;
        m_acc  = 0;
        m_step = cnd(k);
    endtask

    // One cycle: advance the model at the edge, compare at the next negedge.
    task automatic step_cycle(input string req, output bit rose);
        int unsigned sum, nxt, cur_in;
        bit exp_edge;
        cur_in = incr;
        @(negedge clk);
        sum = m_acc + m_step;
        nxt = sum % MODV;
        exp_edge = ((nxt >> N) & 1) && !((m_acc >> N) & 1);
        if (sum >= MODV) m_step = cnd(cur_in);
        m_acc = nxt;
        rose = exp_edge;
        chk({req, " clk_o"}, clk_o, (m_acc >> N) & 1);
        chk("R6 edge_o", edge_o, exp_edge);
    endtask

    initial begin
        bit r;
        int unsigned lfsr;
        int rises;
        // Full sweep over every increment code.
        for (int k = 0; k < int'(MODV); k++) begin
            do_reset(k);
            rises = 0;
            for (int c = 0; c < int'(MODV); c++) begin
                step_cycle("R2", r);
                if (edge_o) rises++;
            end
            if (k == 0)
                chk("R3 rises at increment 0", rises, 1);
            else if (k > int'(LIM))
                chk("R4 rises at clamped increment", rises, LIM);
            else
                chk("R5 rises per 2^(N+1) cycles", rises, k);
            for (int c = 0; c < int'(MODV); c++) step_cycle("R2", r);
        end
        // R4: at maximum rate clk_o toggles every cycle.
        do_reset(LIM);
        for (int c = 0; c < 8; c++) begin
            step_cycle("R4", r);
            chk("R4 toggle", clk_o, (c + 1) % 2);
        end
        // R7: increment changes on every cycle, landing on and off wrap edges.
        do_reset(3);
        lfsr = 32'h1ACE;
        for (int c = 0; c < 600; c++) begin
            step_cycle("R7", r);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[2:0] != 0) incr = (N+1)'(lfsr[12:8]);
        end
        // R1: reset in mid-run returns to the start state.
        do_reset(15);
        for (int c = 0; c < 40; c++) step_cycle("R5", r);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule